// File: doc/BRIEF.md
# Serial-Output Binary Field Multiplier (Trinomial Reduction)

This block forms the product of two elements of GF(2^M). Each element is held as M binary coordinates over the polynomial basis, and the product is reduced modulo the trinomial x^M + x^K + 1. All arithmetic is carry-free: every accumulation is an exclusive-OR.

The result does not appear as one word at the end. It leaves the block as a stream of single coordinates, one per clock, starting with the constant coefficient. Each bit is marked as valid and carries its coefficient index. A consumer can therefore start on the low-order coordinates while the high-order ones are still being formed.

A one-cycle start strobe captures both operands, provided the block is idle. Bit c_i is the inner product, over GF(2), of operand B with row i of the reduction matrix of operand A. Element (i,j) of that matrix is coefficient i of A·x^j mod f. The rows are not stored. A recurrence builds each row from the previous one, so only one row register is needed.

Top module: `gf2m_serial_mul`

## Requirements
- R1: While reset is held, and after reset until the first accepted start, `prod_valid` and `done` are low and `prod_idx` is 0.
- R2: A start sampled high while idle captures `opa` and `opb`. On the next cycle `prod_valid` is high and `prod_idx` is 0.
- R3: The bit presented with index i equals coefficient i of (opa·opb mod x^M + x^K + 1). The coefficient of x^i sits at bit position i of each operand. Partial products are combined with XOR, and this holds for zero, one and all-ones operands.
- R4: One product bit is presented per cycle for exactly M consecutive cycles. The index rises by one each cycle, from 0 to M-1.
- R5: `done` is high for exactly one cycle, together with the bit whose index is M-1. `prod_valid` is low on the following cycle.
- R6: A start sampled while a product is being emitted is ignored. Changes on `opa` and `opb` after capture do not alter the product being emitted.
- R7: A start sampled in the cycle right after `done` is accepted. The new product then begins one cycle later.
- R8: M and K are parameters with 0 < K < M. The defaults are M = 233 and K = 74, and the index width is derived from M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to capture operands and begin a product |
| opa | input | M | First operand, polynomial-basis coordinates |
| opb | input | M | Second operand, polynomial-basis coordinates |
| prod_bit | output | 1 | Current product coordinate |
| prod_valid | output | 1 | `prod_bit` and `prod_idx` are meaningful |
| prod_idx | output | clog2(M) | Index i of the coordinate on `prod_bit` |
| done | output | 1 | Marks the last coordinate, index M-1 |

## Verification
Two events can land in the same cycle: the last coordinate leaving with `done`, and a start request for the next product. The bench raises start in the cycle that carries `done`, with fresh operands, and holds it for one more cycle. The cycle after `done` must show `prod_valid` low, which proves the first request was ignored. The request held into the next cycle must then launch a product at index 0, and that product is compared against the model for the new operands. A start is also raised and operands are scrambled in the middle of a product, and the stream must still match the operands captured at launch.

// File: rtl/gfso_pkg.sv
package gfso_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gfso_state_e;

endpackage

// File: rtl/gfso_msb_seq.sv
// Produces s[j] = coefficient M-1 of (a * x^j mod f) for j = 0..M-2.
// This is row M-1 of the reduction matrix; the row recurrence needs it
// to fold the wrap-around term into rows 0 and K.
module gfso_msb_seq #(
  parameter int M = 233,
  parameter int K = 74
) (
  input  logic [M-1:0] a,
  output logic [M-2:0] s
);

  localparam logic [M-1:0] POLY_LOW = (M'(1) << K) | M'(1);

  function automatic logic [M-2:0] msb_trace(input logic [M-1:0] val);
    logic [M-1:0] v;
    logic [M-2:0] r;
    v = val;
    r = '0;
    for (int j = 0; j < M - 1; j++) begin
      r[j] = v[M-1];
      v    = {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY_LOW : '0);
    end
    return r;
  endfunction

  assign s = msb_trace(a);

endmodule

// File: rtl/gfso_rowgen.sv
// Holds row i of the reduction matrix and advances it to row i+1.
//   row_i[0] = a_i
//   row_i[j] = row_(i-1)[j-1] ^ (i == K ? s[j-1] : 0)   for j >= 1
//   row_0[j] = s[j-1]                                   for j >= 1
module gfso_rowgen #(
  parameter int M = 233
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         fold_k,
  input  logic [M-1:0] a_in,
  input  logic [M-2:0] msb_in,
  output logic [M-1:0] row
);

  logic [M-2:0] msb_q;
  logic [M-1:0] a_sh;   // holds a >> (i+1)
  logic [M-1:0] row_q;
  logic [M-1:0] row_nxt;
  logic [M-1:0] fold_vec;

  assign fold_vec = fold_k ? {msb_q, 1'b0} : '0;
  assign row_nxt  = {row_q[M-2:0], a_sh[0]} ^ fold_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= '0;
      a_sh  <= '0;
      row_q <= '0;
    end else if (load) begin
      msb_q <= msb_in;
      a_sh  <= {1'b0, a_in[M-1:1]};
      row_q <= {msb_in, a_in[0]};
    end else if (step) begin
      a_sh  <= {1'b0, a_sh[M-1:1]};
      row_q <= row_nxt;
    end
  end

  assign row = row_q;

endmodule

// File: rtl/gfso_dot.sv
// GF(2) inner product: AND then XOR-reduce.
module gfso_dot #(
  parameter int M = 233
) (
  input  logic [M-1:0] row,
  input  logic [M-1:0] vec,
  output logic         bit_o
);

  function automatic logic gf2_dot(input logic [M-1:0] x, input logic [M-1:0] y);
    return ^(x & y);
  endfunction

  assign bit_o = gf2_dot(row, vec);

endmodule

// File: rtl/gfso_seq.sv
module gfso_seq
  import gfso_pkg::*;
#(
  parameter int M  = 233,
  parameter int K  = 74,
  parameter int IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          step,
  output logic          last,
  output logic          fold_k,
  output logic          busy,
  output logic [IW-1:0] idx
);

  localparam logic [IW-1:0] IDX_LAST = IW'(M - 1);
  localparam logic [IW-1:0] IDX_PREK = IW'(K - 1);

  gfso_state_e  state_q;
  logic [IW-1:0] idx_q;

  assign busy   = (state_q == ST_RUN);
  assign accept = start && !busy;
  assign last   = busy && (idx_q == IDX_LAST);
  assign step   = busy && !last;
  assign fold_k = step && (idx_q == IDX_PREK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
    end else if (last) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (step) begin
      idx_q   <= idx_q + 1'b1;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/gf2m_serial_mul.sv
module gf2m_serial_mul #(
  parameter int M = 233,
  parameter int K = 74
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [M-1:0]         opa,
  input  logic [M-1:0]         opb,
  output logic                 prod_bit,
  output logic                 prod_valid,
  output logic [$clog2(M)-1:0] prod_idx,
  output logic                 done
);

  localparam int IW = $clog2(M);

  logic          accept;
  logic          step;
  logic          last;
  logic          fold_k;
  logic          busy;
  logic [IW-1:0] idx;
  logic [M-2:0]  msb_seq;
  logic [M-1:0]  row;
  logic [M-1:0]  b_q;

  gfso_seq #(.M(M), .K(K), .IW(IW)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .step   (step),
    .last   (last),
    .fold_k (fold_k),
    .busy   (busy),
    .idx    (idx)
  );

  gfso_msb_seq #(.M(M), .K(K)) msb_i (
    .a (opa),
    .s (msb_seq)
  );

  gfso_rowgen #(.M(M)) row_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (step),
    .fold_k (fold_k),
    .a_in   (opa),
    .msb_in (msb_seq),
    .row    (row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_q <= '0;
    else if (accept) b_q <= opb;
  end

  gfso_dot #(.M(M)) dot_i (
    .row   (row),
    .vec   (b_q),
    .bit_o (prod_bit)
  );

  assign prod_valid = busy;
  assign prod_idx   = idx;
  assign done       = last;

endmodule

// File: rtl/gfso_chk.sv
module gfso_chk #(
  parameter int M  = 233,
  parameter int K  = 74,
  parameter int IW = $clog2(M)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prod_valid,
  input logic [IW-1:0] prod_idx,
  input logic          done,
  input logic          accept,
  input logic          fold_k,
  input logic [M-1:0]  b_q
);

  initial begin
    a_param_r8: assert (K > 0 && K < M)
      else $error("R8 K must lie strictly between 0 and M");
  end

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> prod_valid && prod_idx == '0);

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid && !done |=> prod_valid && prod_idx == $past(prod_idx) + 1'b1);

  p_done_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod_valid && prod_idx == IW'(M - 1));

  p_done_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !prod_valid && !done);

  p_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prod_valid && !done |=> $stable(b_q));

  p_fold_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fold_k |-> prod_valid && prod_idx == IW'(K - 1));

endmodule

bind gf2m_serial_mul gfso_chk #(.M(M), .K(K), .IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .prod_valid (prod_valid),
  .prod_idx   (prod_idx),
  .done       (done),
  .accept     (accept),
  .fold_k     (fold_k),
  .b_q        (b_q)
);

// File: tb/gf2m_serial_mul_tb_top.sv
module gf2m_serial_mul_tb_top;

  localparam int M          = 233;
  localparam int K          = 74;
  localparam int IW         = $clog2(M);
  localparam int CLK_PERIOD = 10;
  localparam int NV         = 9;
  localparam int NRAND      = 6;

  localparam logic [M-1:0] ONE  = M'(1);
  localparam logic [M-1:0] ALL  = {M{1'b1}};
  localparam logic [M-1:0] TOPB = ONE << (M - 1);
  localparam logic [M-1:0] XK   = ONE << K;
  localparam logic [M-1:0] XMK  = ONE << (M - K);
  localparam logic [M-1:0] ALT  = M'({((M + 1) / 2){2'b01}});

  localparam logic [M-1:0] VA [NV] = '{'0,  ONE, ALL, ALL, TOPB, XK,  ALT,  ONE, ALL};
  localparam logic [M-1:0] VB [NV] = '{ALL, ALL, ALL, ONE, TOPB, XMK, ~ALT, ONE, '0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [M-1:0]  opa = '0;
  logic [M-1:0]  opb = '0;
  logic          prod_bit;
  logic          prod_valid;
  logic [IW-1:0] prod_idx;
  logic          done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gf2m_serial_mul #(.M(M), .K(K)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opa        (opa),
    .opb        (opb),
    .prod_bit   (prod_bit),
    .prod_valid (prod_valid),
    .prod_idx   (prod_idx),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Schoolbook carry-less product, then fold the top half down term by term.
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [2*M-2:0] p;
    p = '0;
    for (int j = 0; j < M; j++)
      if (b[j]) p ^= ({{(M-1){1'b0}}, a} << j);
    for (int d = 2*M-2; d >= M; d--) begin
      if (p[d]) begin
        p[d]         = 1'b0;
        p[d - M]     = ~p[d - M];
        p[d - M + K] = ~p[d - M + K];
      end
    end
    return p[M-1:0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [M-1:0] v;
    v = '0;
    for (int w = 0; w < 8; w++) v = {v[M-33:0], 32'($urandom)};
    return v;
  endfunction

  task automatic launch(input logic [M-1:0] a, input logic [M-1:0] b);
    @(negedge clk);
    opa   = a;
    opb   = b;
    start = 1'b1;
  endtask

  task automatic collect(input logic [M-1:0] exp, input string req, input bit poke,
                         input bit chain, input logic [M-1:0] na, input logic [M-1:0] nb);
    logic [M-1:0] got;
    bit valid_ok, idx_ok, done_ok;
    got = '0;
    valid_ok = 1'b1;
    idx_ok = 1'b1;
    done_ok = 1'b1;
    for (int i = 0; i < M; i++) begin
      @(negedge clk);
      if (i == 0) start = 1'b0;
      if (!prod_valid) valid_ok = 1'b0;
      if (prod_idx != IW'(i)) idx_ok = 1'b0;
      if (done != (i == M - 1)) done_ok = 1'b0;
      got[i] = prod_bit;
      if (poke && i == 40) begin start = 1'b1; opa = ~opa; opb = ~opb; end
      if (poke && i == 41) begin opa = rnd(); opb = rnd(); end
      if (poke && i == 42) start = 1'b0;
      if (chain && i == M - 1) begin opa = na; opb = nb; start = 1'b1; end
    end
    chk(got == exp, req, "product bits", got, exp);
    chk(valid_ok && idx_ok, "R2 R4", "valid/index run 0..M-1",
        M'({valid_ok, idx_ok}), M'(2'b11));
    chk(done_ok, "R5", "done only on index M-1", M'(done_ok), ONE);
    @(negedge clk);
    chk(!prod_valid && !done, "R5", "idle cycle after done",
        M'({prod_valid, done}), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog: run still active, actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] ra, rb, ca, cb;

    // R1: quiet during and after reset
    repeat (3) @(negedge clk);
    chk(!prod_valid, "R1", "valid in reset", M'(prod_valid), '0);
    chk(!done, "R1", "done in reset", M'(done), '0);
    chk(prod_idx == '0, "R1", "index in reset", M'(prod_idx), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!prod_valid && !done && prod_idx == '0, "R1", "idle after reset",
        M'({prod_valid, done, prod_idx}), '0);

    // R3: table of corner operands (zero, one, all-ones, x^(M-1), x^K, patterns)
    for (int v = 0; v < NV; v++) begin
      launch(VA[v], VB[v]);
      collect(ref_mul(VA[v], VB[v]), "R3", 1'b0, 1'b0, '0, '0);
    end

    // R3: random operands
    for (int r = 0; r < NRAND; r++) begin
      ra = rnd();
      rb = rnd();
      launch(ra, rb);
      collect(ref_mul(ra, rb), "R3", 1'b0, 1'b0, '0, '0);
    end

    // R6: start and operand changes mid-product are ignored
    ra = rnd();
    rb = rnd();
    launch(ra, rb);
    collect(ref_mul(ra, rb), "R6", 1'b1, 1'b0, '0, '0);

    // R7: start raised on the done cycle (ignored) and held one more cycle (taken)
    ra = rnd();
    rb = rnd();
    ca = rnd();
    cb = ALL;
    launch(ra, rb);
    collect(ref_mul(ra, rb), "R3", 1'b0, 1'b1, ca, cb);
    collect(ref_mul(ca, cb), "R7", 1'b0, 1'b0, '0, '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule